// File: doc/BRIEF.md
# Dual-Owner Hardware Semaphore Bank

This block keeps eight hardware semaphores that a host CPU and a coprocessor core share. Each semaphore is free, held by the host, or held by the coprocessor. It is never held by both sides at once. Ownership lives in a per-semaphore state register. A side can change that state only while the semaphore is free, or while that side holds it.

The host sees the bank as one 16-bit register. A write carries a per-bit enable mask in the upper byte and new ownership values in the lower byte. A read returns the host's ownership bits. The coprocessor side has separate lock and release request vectors, and gets back a status vector of the semaphores it holds. When both sides try to take the same free semaphore in the same cycle, the coprocessor wins. A host attempt on a semaphore the coprocessor holds fails without any error, and it shows as not held in the host readback.

Top module: `hw_sem_bank`

## Requirements
- R1: After reset every semaphore is free: `host_rdata_o` reads 0x0000 and `cop_held_o` reads 0x00.
- R2: On a host write, semaphore i is affected only when mask bit `host_wdata_i[8+i]` is 1. It then requests ownership if data bit `host_wdata_i[i]` is 1 and releases if that bit is 0. A write with a zero mask changes nothing.
- R3: `host_rdata_o[7:0]` has bit i set exactly when the host holds semaphore i, and `host_rdata_o[15:8]` is always zero. Writing 0x5050 to a free bank reads back 0x0050.
- R4: A host write of 0xFF00 releases every semaphore the host holds, so readback becomes 0x0000.
- R5: A host request on a semaphore the coprocessor holds fails, and that bit reads 0. The other bits of the same write are still applied as the mask directs.
- R6: Once the coprocessor releases a semaphore, a later host write can take it, and it then reads back as set.
- R7: A coprocessor lock request (`cop_lock_i[i]`) succeeds only if semaphore i is free. On a host-held semaphore the request leaves the state unchanged.
- R8: If the coprocessor locks and the host sets the same free semaphore in one cycle, the coprocessor takes it and the host bit stays 0.
- R9: A side can release only semaphores it holds. A coprocessor release on a host-held semaphore has no effect. A masked host clear on a coprocessor-held semaphore has no effect.
- R10: A change takes effect on the clock edge where the write or request is sampled, and shows at the outputs from the next cycle. Without a host write the host view does not change. Without a lock or release request the coprocessor view does not change.
- R11: No semaphore is ever reported as held by both sides (`host_rdata_o[7:0] & cop_held_o` is zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Host write strobe, one cycle per write |
| host_wdata_i | input | 16 | Host write value: [15:8] enable mask, [7:0] ownership values |
| host_rdata_o | output | 16 | Host readback: [7:0] host ownership, [15:8] zero |
| cop_lock_i | input | 8 | Coprocessor lock request, one bit per semaphore |
| cop_release_i | input | 8 | Coprocessor release request, one bit per semaphore |
| cop_held_o | output | 8 | Semaphores held by the coprocessor |

## Verification
Every result is due exactly one cycle after its stimulus. A write or request sampled at a rising edge changes the state register on that edge, and both outputs are combinational views of that register. The bench therefore drives inputs at the falling edge. It samples both outputs shortly after the next rising edge and compares them with a bench model that it advanced on the same edge. Directed steps cover the readback and release patterns, the refused lock and release cases, and the same-cycle tie. A seeded random phase then checks the same one-cycle rule on every cycle, together with mutual exclusion.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int unsigned SEM_COUNT = 8;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_COP  = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_host_decode.sv
module sem_host_decode #(
  parameter int unsigned N = 8,
  localparam int unsigned W = 2 * N
) (
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [N-1:0] set_o,
  output logic [N-1:0] clr_o
);
  logic [N-1:0] en;
  logic [N-1:0] val;

  assign en    = {N{we_i}} & wdata_i[W-1:N];
  assign val   = wdata_i[N-1:0];
  assign set_o = en & val;
  assign clr_o = en & ~val;
endmodule

// File: rtl/sem_cell.sv
module sem_cell
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_set_i,
  input  logic host_clr_i,
  input  logic cop_lock_i,
  input  logic cop_rel_i,
  output logic host_own_o,
  output logic cop_own_o
);
  owner_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_FREE: begin
        if (cop_lock_i)      state_d = OWN_COP;   // coprocessor wins a tie
        else if (host_set_i) state_d = OWN_HOST;
      end
      OWN_HOST: if (host_clr_i) state_d = OWN_FREE;
      OWN_COP:  if (cop_rel_i)  state_d = OWN_FREE;
      default:  state_d = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= OWN_FREE;
    else         state_q <= state_d;
  end

  assign host_own_o = (state_q == OWN_HOST);
  assign cop_own_o  = (state_q == OWN_COP);

  assert_cop_lock_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OWN_FREE && cop_lock_i) |=> cop_own_o);
  assert_cop_lock_refused_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OWN_HOST && cop_lock_i && !host_clr_i) |=> (host_own_o && !cop_own_o));
  assert_tie_cop_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OWN_FREE && cop_lock_i && host_set_i) |=> (cop_own_o && !host_own_o));
  assert_host_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OWN_COP && !cop_rel_i) |=> (cop_own_o && !host_own_o));
  assert_cop_release_foreign_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == OWN_HOST && cop_rel_i && !host_clr_i) |=> host_own_o);
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
  parameter int unsigned N = 8,
  localparam int unsigned W = 2 * N
) (
  input  logic [N-1:0] host_own_i,
  output logic [W-1:0] rdata_o
);
  assign rdata_o = {{N{1'b0}}, host_own_i};
endmodule

// File: rtl/hw_sem_bank.sv
module hw_sem_bank #(
  parameter int unsigned N = sem_pkg::SEM_COUNT,
  localparam int unsigned W = 2 * N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         host_we_i,
  input  logic [W-1:0] host_wdata_i,
  output logic [W-1:0] host_rdata_o,
  input  logic [N-1:0] cop_lock_i,
  input  logic [N-1:0] cop_release_i,
  output logic [N-1:0] cop_held_o
);
  logic [N-1:0] host_set, host_clr, host_own, cop_own;

  sem_host_decode #(.N(N)) u_decode (
    .we_i    (host_we_i),
    .wdata_i (host_wdata_i),
    .set_o   (host_set),
    .clr_o   (host_clr)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    sem_cell u_cell (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .host_set_i (host_set[i]),
      .host_clr_i (host_clr[i]),
      .cop_lock_i (cop_lock_i[i]),
      .cop_rel_i  (cop_release_i[i]),
      .host_own_o (host_own[i]),
      .cop_own_o  (cop_own[i])
    );
  end

  sem_readback #(.N(N)) u_readback (
    .host_own_i (host_own),
    .rdata_o    (host_rdata_o)
  );

  assign cop_held_o = cop_own;

  assert_exclusive_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rdata_o[N-1:0] & cop_held_o) == '0);
  assert_host_view_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_we_i |=> $stable(host_rdata_o));
  assert_cop_view_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_lock_i == '0 && cop_release_i == '0) |=> $stable(cop_held_o));
endmodule

// File: tb/hw_sem_bank_bench.sv
module hw_sem_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  lock = '0, rel = '0, cop_held;

  logic [7:0]  m_host = '0, m_cop = '0;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  hw_sem_bank u_hw_sem_bank (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .host_we_i     (we),
    .host_wdata_i  (wdata),
    .host_rdata_o  (rdata),
    .cop_lock_i    (lock),
    .cop_release_i (rel),
    .cop_held_o    (cop_held)
  );

  function automatic logic [15:0] next_model(logic [7:0] h, logic [7:0] c, logic w,
                                             logic [15:0] d, logic [7:0] lk, logic [7:0] rl);
    logic [7:0] nh = h, nc = c;
    for (int i = 0; i < 8; i++) begin
      if (c[i]) begin
        if (rl[i]) nc[i] = 1'b0;
      end else if (h[i]) begin
        if (w && d[8+i] && !d[i]) nh[i] = 1'b0;
      end else begin
        if (lk[i]) nc[i] = 1'b1;
        else if (w && d[8+i] && d[i]) nh[i] = 1'b1;
      end
    end
    return {nc, nh};
  endfunction

  task automatic check(string req);
    n_run++;
    if (rdata !== {8'h00, m_host} || cop_held !== m_cop) begin
      n_fail++;
      $display("FAIL %s: host=%h cop=%h expected host=%h cop=%h",
               req, rdata, cop_held, {8'h00, m_host}, m_cop);
    end
    if ((rdata[7:0] & cop_held) != 8'h00) begin
      n_fail++;
      $display("FAIL R11: overlap host=%h cop=%h expected none", rdata[7:0], cop_held);
    end
  endtask

  task automatic step(logic w, logic [15:0] d, logic [7:0] lk, logic [7:0] rl, string req);
    logic [15:0] nm;
    @(negedge clk);
    we = w; wdata = d; lock = lk; rel = rl;
    nm = next_model(m_host, m_cop, w, d, lk, rl);
    @(posedge clk);
    m_host = nm[7:0];
    m_cop  = nm[15:8];
    #2;
    check(req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R1 after release");

    step(1, 16'h5050, 8'h00, 8'h00, "R3 write 5050 reads 0050");
    step(1, 16'h00FF, 8'h00, 8'h00, "R2 zero mask no change");
    step(1, 16'hFF00, 8'h00, 8'h00, "R4 FF00 clears all");
    step(0, 16'h0000, 8'h08, 8'h00, "R7 lock free sem");
    step(1, 16'hFF08, 8'h00, 8'h00, "R5 host set on cop-held");
    step(1, 16'h0909, 8'h00, 8'h00, "R5 other bits applied");
    step(1, 16'h0800, 8'h00, 8'h00, "R9 host clear on cop-held");
    step(0, 16'h0000, 8'h00, 8'h01, "R9 cop release on host-held");
    step(0, 16'h0000, 8'h01, 8'h00, "R7 lock on host-held refused");
    step(0, 16'h0000, 8'h00, 8'h08, "R6 cop release");
    step(1, 16'h0808, 8'h00, 8'h00, "R6 host takes released sem");
    step(1, 16'h2020, 8'h20, 8'h00, "R8 tie coprocessor wins");
    step(0, 16'hFFFF, 8'h00, 8'h00, "R10 idle no change");
    step(1, 16'h0202, 8'h00, 8'h00, "R10 visible next cycle");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] d;
      logic [7:0]  lk, rl;
      logic        w;
      w  = ($urandom % 3) != 0;
      d  = 16'($urandom);
      lk = 8'($urandom) & 8'($urandom);
      rl = 8'($urandom) & 8'($urandom);
      step(w, d, lk, rl, "R2 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EA1));
  end
endmodule